// File: doc/BRIEF.md
# SPI Block Transfer Controller

This block is a memory-mapped SPI master that moves a programmed number of bytes in one direction only. Software selects a clock divider and a direction, loads a byte count and sets a start bit. The block then clocks bytes out of, or into, a four-word 32-bit data FIFO until the count is reached. On a write to the device, the CPU fills the FIFO. On a read from the device, the CPU drains it.

Chip select is asserted when a transfer starts. It stays asserted after the last byte, so software can chain several block transfers into one device command. Software releases chip select by writing zero to a separate select register. Each finished transfer raises an event flag, which software clears by writing one to it.

The register bus is a simple single-cycle strobe interface. A word index on `bus_addr` picks the register: 0 control, 1 select, 2 length, 3 data, 4 status, 5 event. Reads are combinational in the strobe cycle. A data read pops the FIFO at the end of that cycle.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset, chip select is high (`spi_cs_n` = 1) and `spi_sclk` is low. The control, select, status and event registers all read as 0.
- R2: The control register (index 0) keeps the divider selector in bits 2:0, a bus-mode bit in bit 12 and the direction in bit 13 (1 = write to the device, 0 = read from the device). Bit 15 reads 1 while a transfer runs and 0 when idle. All other bits read 0. Writes to the control register are ignored while busy.
- R3: The length register (index 2) stores a byte count in bits 20:0. Bits 31:21 of a write are dropped and read back as 0.
- R4: Writing control with bit 15 set while idle starts a transfer. Chip select drops and the select register (index 1) reads 1. With a length of 0 the transfer ends at once, with no SCK pulse.
- R5: SPI mode 0 is used. SCK idles low, its period is 2^(sel+1) system clocks within a byte, and each byte goes out MSB first.
- R6: On a write transfer, bytes are taken from FIFO words least significant byte first. The unused upper bytes of the final partial word are dropped with that word.
- R7: On a read transfer, received bytes are packed least significant byte first. A final partial word is padded with zero bytes.
- R8: A write transfer pauses while the FIFO is empty. A read transfer pauses while the FIFO is full. Both resume once software services the FIFO.
- R9: The FIFO holds 4 words, and status bit 0 (index 4) reads 1 when it is full. Writes to the data register (index 3) push only when the direction is write and the FIFO is not full. Reads of the data register pop only when the direction is read.
- R10: Chip select stays asserted after a transfer ends. An idle write of 0 to select bit 0 releases it. A write of 1 to the select register has no effect.
- R11: The end of every transfer sets event bit 0 (index 5). Writing 1 to that bit clears it, and writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Data to the device |
| spi_miso | input | 1 | Data from the device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench starves a write transfer and floods a read transfer, then checks that SCK stops at exactly the byte count the FIFO allows. A design that skipped the stall would send stale bytes or drop received ones. It also runs transfers that end mid-word. A wrong pop rule would leak padding bytes onto MOSI or shift later words, and wrong packing would leave garbage above the last received byte. A chip select model is compared on every clock, so a design that released select at the end of a transfer, or on a write of 1, is caught in the cycle it happens. Zero-length transfers and register accesses made in the wrong direction are checked through the status and event bits.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_SEL  = 3'd1,
        REG_LEN  = 3'd2,
        REG_DATA = 3'd3,
        REG_STAT = 3'd4,
        REG_EVT  = 3'd5
    } reg_idx_e;

    localparam int CTRL_MODE_BIT = 12;
    localparam int CTRL_DIR_BIT  = 13;
    localparam int CTRL_GO_BIT   = 15;
endpackage

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rp;
        logic [PTR_W-1:0]        wp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp        = bump(q.wp);
        end
        if (do_pop) d.rp = bump(q.rp);
        if (do_push && !do_pop)      d.cnt = q.cnt + CNT_W'(1);
        else if (do_pop && !do_push) d.cnt = q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign full  = (q.cnt == CNT_W'(DEPTH));
    assign empty = (q.cnt == '0);
endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
    parameter int BAUD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] baud,
    input  logic              start,
    input  logic [7:0]        tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [7:0]        rx_byte
);
    localparam int DIV_W = 2 ** BAUD_W;

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] div;
        logic [7:0]       tx;
        logic [7:0]       rx;
    } sh_t;

    sh_t              q, d;
    logic [DIV_W-1:0] half_m1;
    logic             tick;

    always_comb begin
        d       = q;
        half_m1 = (DIV_W'(1) << baud) - DIV_W'(1);
        tick    = q.active && (q.div == half_m1);
        done    = tick && q.sck && (q.bitn == 3'd7);
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.sck    = 1'b0;
                d.bitn   = '0;
                d.div    = '0;
                d.tx     = tx_byte;
            end
        end else if (tick) begin
            d.div = '0;
            d.sck = !q.sck;
            if (!q.sck) begin
                d.rx = {q.rx[6:0], miso};
            end else if (q.bitn == 3'd7) begin
                d.active = 1'b0;
            end else begin
                d.tx   = {q.tx[6:0], 1'b0};
                d.bitn = q.bitn + 3'd1;
            end
        end else begin
            d.div = q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.sck;
    assign mosi    = q.active ? q.tx[7] : 1'b0;
    assign rx_byte = q.rx;
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int BAUD_W     = 3,
    parameter int LEN_W      = 21,
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;
    localparam int IDX_W  = $clog2(BYTES);

    typedef struct packed {
        logic [BAUD_W-1:0] baud;
        logic              mode;
        logic              dir;
        logic              busy;
        logic              sel;
        logic              evt;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic              flight;
        logic [DATA_W-1:0] asm_w;
    } ctl_t;

    ctl_t q, d;

    logic              f_push, f_pop, f_full, f_empty;
    logic [DATA_W-1:0] f_wdata, f_head;
    logic              cpu_push, cpu_pop, blk_push, blk_pop;
    logic [DATA_W-1:0] blk_word;
    logic              sh_start, sh_done;
    logic [7:0]        sh_tx, sh_rx;
    logic [IDX_W-1:0]  pos, done_pos;
    logic [LEN_W-1:0]  prev_idx;
    logic              last_launch, can_go;
    logic              busy_w, evt_w;

    always_comb begin
        d           = q;
        blk_push    = 1'b0;
        blk_pop     = 1'b0;
        blk_word    = '0;
        sh_start    = 1'b0;
        sh_tx       = '0;
        pos         = q.idx[IDX_W-1:0];
        prev_idx    = q.idx - LEN_W'(1);
        done_pos    = prev_idx[IDX_W-1:0];
        last_launch = (q.idx + LEN_W'(1) == q.len);
        can_go      = q.dir ? !f_empty : !f_full;

        cpu_push = bus_wr && (bus_addr == REG_DATA) && q.dir && !f_full;
        cpu_pop  = bus_rd && (bus_addr == REG_DATA) && !q.dir && !f_empty;

        if (bus_wr && !q.busy) begin
            if (bus_addr == REG_CTRL) begin
                d.baud = bus_wdata[BAUD_W-1:0];
                d.mode = bus_wdata[CTRL_MODE_BIT];
                d.dir  = bus_wdata[CTRL_DIR_BIT];
                if (bus_wdata[CTRL_GO_BIT]) begin
                    d.busy   = 1'b1;
                    d.sel    = 1'b1;
                    d.idx    = '0;
                    d.flight = 1'b0;
                    d.asm_w  = '0;
                end
            end
            if (bus_addr == REG_LEN) d.len = bus_wdata[LEN_W-1:0];
            if (bus_addr == REG_SEL && !bus_wdata[0]) d.sel = 1'b0;
        end
        if (bus_wr && (bus_addr == REG_EVT) && bus_wdata[0]) d.evt = 1'b0;

        if (q.busy) begin
            if (!q.flight && (q.idx != q.len)) begin
                if (can_go) begin
                    sh_start = 1'b1;
                    for (int b = 0; b < BYTES; b++)
                        if (IDX_W'(b) == pos) sh_tx = f_head[8*b +: 8];
                    d.idx    = q.idx + LEN_W'(1);
                    d.flight = 1'b1;
                    if (q.dir && (pos == IDX_W'(BYTES - 1) || last_launch))
                        blk_pop = 1'b1;
                end
            end else if (q.flight && sh_done) begin
                d.flight = 1'b0;
                if (!q.dir) begin
                    blk_word = q.asm_w;
                    for (int b = 0; b < BYTES; b++)
                        if (IDX_W'(b) == done_pos) blk_word[8*b +: 8] = sh_rx;
                    if (done_pos == IDX_W'(BYTES - 1) || q.idx == q.len) begin
                        blk_push = 1'b1;
                        d.asm_w  = '0;
                    end else begin
                        d.asm_w = blk_word;
                    end
                end
            end else if (!q.flight && (q.idx == q.len)) begin
                d.busy = 1'b0;
                d.evt  = 1'b1;
            end
        end

        f_push  = q.dir ? cpu_push : blk_push;
        f_pop   = q.dir ? blk_pop : cpu_pop;
        f_wdata = q.dir ? bus_wdata : blk_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[BAUD_W-1:0]    = q.baud;
                bus_rdata[CTRL_MODE_BIT] = q.mode;
                bus_rdata[CTRL_DIR_BIT]  = q.dir;
                bus_rdata[CTRL_GO_BIT]   = q.busy;
            end
            REG_SEL:  bus_rdata[0] = q.sel;
            REG_LEN:  bus_rdata[LEN_W-1:0] = q.len;
            REG_DATA: bus_rdata = f_head;
            REG_STAT: bus_rdata[0] = f_full;
            REG_EVT:  bus_rdata[0] = q.evt;
            default:  bus_rdata = '0;
        endcase
    end

    spi_xfer_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .pop   (f_pop),
        .wdata (f_wdata),
        .head  (f_head),
        .full  (f_full),
        .empty (f_empty)
    );

    spi_xfer_shifter #(.BAUD_W(BAUD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .baud    (q.baud),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    assign spi_cs_n = !q.sel;
    assign busy_w   = q.busy;
    assign evt_w    = q.evt;
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       cs_n,
    input logic       busy,
    input logic       evt,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [31:0] bus_wdata
);
    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);

    // R11
    evt_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt);

    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(bus_wr && bus_addr == 3'd1 && !bus_wdata[0]));
endmodule

bind spi_xfer_ctrl spi_xfer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .busy      (busy_w),
    .evt       (evt_w),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_spi_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_spi_xfer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    int checks = 0, errors = 0;
    int cyc = 0, last_rise = 0, per = 0;
    int rise_cnt = 0, base = 0;
    bit model_sel = 0, started = 0, finished = 0;
    logic [7:0] cap = '0;
    logic [7:0] got[$];

    always #2.5 clk = ~clk;

    spi_xfer_ctrl u0 (.*);

    function automatic logic [7:0] dev_b(int k);
        return 8'(8'h3C + k * 17);
    endfunction
    function automatic logic dev_bit(int n);
        logic [7:0] v = dev_b(n / 8);
        return v[7 - (n % 8)];
    endfunction
    function automatic logic [31:0] dev_w(int k0);
        return {dev_b(k0 + 3), dev_b(k0 + 2), dev_b(k0 + 1), dev_b(k0)};
    endfunction

    assign spi_miso = dev_bit(rise_cnt - base);

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge spi_sclk) begin
        cap = {cap[6:0], spi_mosi};
        rise_cnt = rise_cnt + 1;
        per = cyc - last_rise;
        last_rise = cyc;
        if (rise_cnt % 8 == 0) got.push_back(cap);
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock reference model of chip select and the idle SCK level
    always @(posedge clk) begin
        #1;
        if (started && !finished) begin
            chk(spi_cs_n == !model_sel, "R10", "cs_n vs model", 32'(spi_cs_n), 32'(!model_sel));
            if (spi_cs_n) chk(!spi_sclk, "R5", "sclk idle low", 32'(spi_sclk), 0);
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        if (a == 3'd0 && v[15]) model_sel = 1;
        if (a == 3'd1 && !v[0]) model_sel = 0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(3'd0, v);
            if (!v[15]) return;
        end
        chk(0, "R4", "transfer never ended", 1, 0);
    endtask

    task automatic release_cs();
        logic [31:0] v;
        wr(3'd5, 32'h1);
        wr(3'd1, 32'h0);
        rd(3'd1, v);
        chk(v == 0, "R10", "select after release", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int g0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        started = 1;
        // R1 reset state
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1", "pins", {spi_cs_n, spi_sclk}, 32'h2);
        rd(3'd0, v); chk(v == 0, "R1", "ctrl", v, 0);
        rd(3'd1, v); chk(v == 0, "R1", "select", v, 0);
        rd(3'd4, v); chk(v == 0, "R1", "status", v, 0);
        rd(3'd5, v); chk(v == 0, "R1", "event", v, 0);

        // R2 control layout, R3 length masking
        wr(3'd0, 32'h0000_3007); rd(3'd0, v); chk(v == 32'h3007, "R2", "ctrl readback", v, 32'h3007);
        wr(3'd0, 32'hFFFF_5FF8); rd(3'd0, v); chk(v == 32'h1000, "R2", "ctrl reserved", v, 32'h1000);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk(v == 32'h1F_FFFF, "R3", "length mask", v, 32'h1F_FFFF);

        // R6 write transfer, 6 bytes, partial final word
        wr(3'd0, 32'h2000);
        wr(3'd3, 32'h4433_2211);
        wr(3'd3, 32'hDDCC_6655);
        wr(3'd2, 6);
        g0 = got.size();
        wr(3'd0, 32'hA000);
        rd(3'd0, v); chk(v == 32'hA000, "R2", "busy bit", v, 32'hA000);
        rd(3'd1, v); chk(v == 1, "R4", "select set", v, 1);
        wr(3'd0, 32'h0000_0007);
        rd(3'd0, v); chk(v == 32'hA000, "R2", "ctrl ignored while busy", v, 32'hA000);
        wait_idle();
        chk(got.size() - g0 == 6, "R6", "byte count", got.size() - g0, 6);
        for (int i = 0; i < 6 && g0 + i < got.size(); i++)
            chk(got[g0 + i] == 8'(8'h11 * (i + 1)), "R6", "mosi byte", got[g0 + i], 8'(8'h11 * (i + 1)));
        rd(3'd5, v); chk(v == 1, "R11", "event set", v, 1);
        wr(3'd5, 32'h0); rd(3'd5, v); chk(v == 1, "R11", "write 0 keeps event", v, 1);
        wr(3'd5, 32'h1); rd(3'd5, v); chk(v == 0, "R11", "event cleared", v, 0);
        repeat (20) @(posedge clk);
        chk(spi_cs_n == 0, "R10", "cs held after end", spi_cs_n, 0);
        wr(3'd1, 32'h1); rd(3'd1, v); chk(v == 1, "R10", "select write 1", v, 1);
        wr(3'd1, 32'h0); rd(3'd1, v); chk(v == 0, "R10", "select released", v, 0);
        wr(3'd1, 32'h1); rd(3'd1, v); chk(v == 0, "R10", "write 1 no reselect", v, 0);

        // R7 read transfer, 5 bytes at divider 1
        wr(3'd2, 5);
        base = rise_cnt;
        wr(3'd0, 32'h8001);
        wait_idle();
        rd(3'd3, v); chk(v == dev_w(0), "R7", "read word 0", v, dev_w(0));
        rd(3'd3, v); chk(v == {24'h0, dev_b(4)}, "R7", "padded word", v, {24'h0, dev_b(4)});
        release_cs();

        // R5 SCK period at divider 2, single byte
        wr(3'd2, 1);
        base = rise_cnt;
        wr(3'd0, 32'h8002);
        wait_idle();
        chk(per == 8, "R5", "sck period div2", per, 8);
        rd(3'd3, v); chk(v == {24'h0, dev_b(0)}, "R7", "single byte word", v, {24'h0, dev_b(0)});
        release_cs();

        // R4 zero length
        wr(3'd2, 0);
        g0 = rise_cnt;
        wr(3'd0, 32'h8000);
        repeat (10) @(posedge clk);
        rd(3'd0, v); chk(v[15] == 0, "R4", "zero length ends", v, 0);
        chk(rise_cnt == g0, "R4", "zero length no sck", rise_cnt - g0, 0);
        rd(3'd5, v); chk(v == 1, "R11", "event on zero length", v, 1);
        release_cs();

        // R8 read stall on full FIFO, 20 bytes
        wr(3'd2, 20);
        base = rise_cnt;
        wr(3'd0, 32'h8000);
        repeat (400) @(posedge clk);
        rd(3'd4, v); chk(v == 1, "R9", "status full", v, 1);
        rd(3'd0, v); chk(v[15] == 1, "R8", "busy while stalled", v[15], 1);
        chk(rise_cnt - base == 128, "R8", "read stall bits", rise_cnt - base, 128);
        for (int k = 0; k < 4; k++) begin
            rd(3'd3, v); chk(v == dev_w(4 * k), "R8", "stalled read word", v, dev_w(4 * k));
        end
        wait_idle();
        rd(3'd3, v); chk(v == dev_w(16), "R8", "last read word", v, dev_w(16));
        release_cs();

        // R8 write stall on empty FIFO, 8 bytes
        wr(3'd0, 32'h2000);
        wr(3'd3, 32'h0403_0201);
        wr(3'd2, 8);
        g0 = got.size();
        wr(3'd0, 32'hA000);
        repeat (300) @(posedge clk);
        chk(got.size() - g0 == 4, "R8", "write stall bytes", got.size() - g0, 4);
        rd(3'd0, v); chk(v[15] == 1, "R8", "busy while starved", v[15], 1);
        wr(3'd3, 32'h0807_0605);
        wait_idle();
        chk(got.size() - g0 == 8, "R8", "write total bytes", got.size() - g0, 8);
        for (int i = 0; i < 8 && g0 + i < got.size(); i++)
            chk(got[g0 + i] == 8'(i + 1), "R6", "resumed byte", got[g0 + i], 8'(i + 1));
        release_cs();

        // R9 direction gating and full flag
        wr(3'd0, 32'h0000);
        for (int k = 0; k < 4; k++) wr(3'd3, 32'hBAD0_0000 + k);
        wr(3'd0, 32'h2000);
        rd(3'd4, v); chk(v == 0, "R9", "read-dir push ignored", v, 0);
        for (int k = 0; k < 5; k++) wr(3'd3, 32'h1000_0000 * (k + 1) + 32'h0101_0101 * k);
        rd(3'd4, v); chk(v == 1, "R9", "full after 4", v, 1);
        rd(3'd3, v);
        rd(3'd4, v); chk(v == 1, "R9", "write-dir pop ignored", v, 1);
        wr(3'd2, 16);
        g0 = got.size();
        wr(3'd0, 32'hA000);
        wait_idle();
        chk(got.size() - g0 == 16, "R9", "drain bytes", got.size() - g0, 16);
        for (int i = 0; i < 16 && g0 + i < got.size(); i++) begin
            automatic int k = i / 4;
            automatic logic [31:0] w = 32'h1000_0000 * (k + 1) + 32'h0101_0101 * k;
            chk(got[g0 + i] == w[8 * (i % 4) +: 8], "R9", "drained byte", got[g0 + i], w[8 * (i % 4) +: 8]);
        end
        rd(3'd4, v); chk(v == 0, "R9", "empty after drain", v, 0);
        release_cs();

        repeat (5) @(posedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule